// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer Interface

This block sits between a minimum-mode 16-bit processor and its memory and IO devices. The processor shares its pins over time. Sixteen lines carry the low address and then data, four lines carry the upper address and then status, and one line carries the byte-high-enable and then status. The block turns these shared lines into separate buses. It latches the 20-bit address and the byte-high-enable while the address strobe is high, and holds them after the strobe falls. It steers data through a two-way transceiver whose enable and direction come straight from the processor's data-enable and transmit/receive pins. It also passes the read, write and memory-versus-IO strobes through a one-way buffer that is always on.

The latch copies all 21 shared lines to its outputs while the strobe is high. A register, loaded on every clock edge during that time, supplies the held value once the strobe falls. The strobe is expected to stay high across at least one rising clock edge. Tri-state pins are modelled on each side as separate in, out and output-enable signals. An undriven output is zero. The data-enable and direction pins are used only inside the block and are not exported.

Top module: `bus_demux_if`

## Requirements
- R1: While `ale_i` is 1, `lat_addr_o` equals {`mux_hi_i`, `mux_ad_i`} (upper lines in bits 19:16) and `lat_bhe_n_o` equals `bhe_st_i`, in the same cycle.
- R2: After `ale_i` falls, `lat_addr_o` and `lat_bhe_n_o` keep the value captured at the last rising clock edge with `ale_i` high, while the shared lines change.
- R3: After reset, with `ale_i` held at 0, `lat_addr_o` and `lat_bhe_n_o` are 0.
- R4: When `den_n_i` is 1, `sys_d_oe` and `mux_ad_oe` are both 0 and `sys_d_o` and `mux_ad_o` are 0, whatever `dtr_i` is.
- R5: When `den_n_i` is 0 and `dtr_i` is 1 (transmit), `sys_d_oe` is 1, `sys_d_o` equals `mux_ad_i`, and `mux_ad_oe` is 0.
- R6: When `den_n_i` is 0 and `dtr_i` is 0 (receive), `mux_ad_oe` is 1, `mux_ad_o` equals `sys_d_i`, and `sys_d_oe` is 0.
- R7: `sys_rd_n_o`, `sys_wr_n_o` and `sys_mio_o` equal `rd_n_i`, `wr_n_i` and `mio_i` at all times after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_ad_i | input | 16 | Shared address/data lines driven by the processor |
| mux_ad_o | output | 16 | Data returned toward the processor's shared lines |
| mux_ad_oe | output | 1 | Drive enable for `mux_ad_o` |
| mux_hi_i | input | 4 | Shared upper-address/status lines |
| bhe_st_i | input | 1 | Shared byte-high-enable/status line (active low) |
| ale_i | input | 1 | Address latch strobe, transparent while high |
| den_n_i | input | 1 | Active-low data transceiver enable |
| dtr_i | input | 1 | Transceiver direction, 1 transmit, 0 receive |
| rd_n_i | input | 1 | Read strobe from the processor |
| wr_n_i | input | 1 | Write strobe from the processor |
| mio_i | input | 1 | Memory-versus-IO select from the processor |
| lat_addr_o | output | 20 | Latched system address |
| lat_bhe_n_o | output | 1 | Latched byte-high-enable |
| sys_d_i | input | 16 | System data bus, read side |
| sys_d_o | output | 16 | System data bus, drive side |
| sys_d_oe | output | 1 | Drive enable for `sys_d_o` |
| sys_rd_n_o | output | 1 | Buffered read strobe |
| sys_wr_n_o | output | 1 | Buffered write strobe |
| sys_mio_o | output | 1 | Buffered memory-versus-IO select |

## Verification
The bench builds the block with its default widths: 16 shared data lines and 4 upper lines. It runs 256 bus cycles. In each one, the address phase, the byte-high-enable, the transceiver mode (off, transmit, receive) and all eight combinations of the control strobes are worked out arithmetically from the cycle index. At these widths every address bit takes both values many times over. Each enable and direction combination meets each strobe pattern. The data phase also drives values on the shared lines that differ from the latched address, so any leak from the lines into the held address is visible.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  typedef enum logic [1:0] {
    XMODE_OFF = 2'd0,
    XMODE_TX  = 2'd1,
    XMODE_RX  = 2'd2
  } xmode_e;

  function automatic xmode_e decode_xmode(input logic en_n, input logic dir);
    if (en_n)     return XMODE_OFF;
    else if (dir) return XMODE_TX;
    else          return XMODE_RX;
  endfunction
endpackage

// File: rtl/bdm_rst_sync.sv
module bdm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q, sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/bdm_addr_latch.sv
module bdm_addr_latch #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] held_q, held_d;

  // load enable written out: capture while the strobe is high
  always_comb held_d = le_i ? d_i : held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign q_o = le_i ? d_i : held_q;

  // R1
  capture_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_i |=> (held_q == $past(d_i)));

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_i && !$past(le_i)) |-> $stable(q_o));
endmodule

// File: rtl/bdm_xcvr.sv
module bdm_xcvr
  import bdm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_n_i,
  input  logic         dir_i,
  input  logic [W-1:0] cpu_i,
  output logic [W-1:0] cpu_o,
  output logic         cpu_oe,
  input  logic [W-1:0] sys_i,
  output logic [W-1:0] sys_o,
  output logic         sys_oe
);
  xmode_e mode;

  always_comb begin
    mode   = decode_xmode(en_n_i, dir_i);
    cpu_oe = 1'b0;
    sys_oe = 1'b0;
    cpu_o  = '0;
    sys_o  = '0;
    unique case (mode)
      XMODE_TX: begin
        sys_oe = 1'b1;
        sys_o  = cpu_i;
      end
      XMODE_RX: begin
        cpu_oe = 1'b1;
        cpu_o  = sys_i;
      end
      default: ;
    endcase
  end

  // R4
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_i |-> (!cpu_oe && !sys_oe));

  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_oe && sys_oe));

  // R6
  rx_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n_i && !dir_i) |-> (cpu_oe && !sys_oe));
endmodule

// File: rtl/bdm_ctrl_buf.sv
module bdm_ctrl_buf #(
  parameter int N = 3
) (
  input  logic [N-1:0] strobe_i,
  output logic [N-1:0] strobe_o
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    assign strobe_o[g] = strobe_i[g];
  end
endmodule

// File: rtl/bus_demux_if.sv
module bus_demux_if #(
  parameter int DATA_W  = 16,
  parameter int UPPER_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         mux_ad_i,
  output logic [DATA_W-1:0]         mux_ad_o,
  output logic                      mux_ad_oe,
  input  logic [UPPER_W-1:0]        mux_hi_i,
  input  logic                      bhe_st_i,
  input  logic                      ale_i,
  input  logic                      den_n_i,
  input  logic                      dtr_i,
  input  logic                      rd_n_i,
  input  logic                      wr_n_i,
  input  logic                      mio_i,
  output logic [DATA_W+UPPER_W-1:0] lat_addr_o,
  output logic                      lat_bhe_n_o,
  input  logic [DATA_W-1:0]         sys_d_i,
  output logic [DATA_W-1:0]         sys_d_o,
  output logic                      sys_d_oe,
  output logic                      sys_rd_n_o,
  output logic                      sys_wr_n_o,
  output logic                      sys_mio_o
);
  localparam int ADDR_W = DATA_W + UPPER_W;
  localparam int LAT_W  = ADDR_W + 1;
  localparam int CTRL_N = 3;

  logic             rst_n_s;
  logic [LAT_W-1:0] lat_d, lat_q;
  logic [CTRL_N-1:0] ctl_d, ctl_q;

  bdm_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_n_o(rst_n_s)
  );

  assign lat_d = {bhe_st_i, mux_hi_i, mux_ad_i};

  bdm_addr_latch #(.W(LAT_W)) u_latch (
    .clk (clk),
    .rst_n(rst_n_s),
    .le_i(ale_i),
    .d_i (lat_d),
    .q_o (lat_q)
  );

  assign lat_addr_o  = lat_q[ADDR_W-1:0];
  assign lat_bhe_n_o = lat_q[ADDR_W];

  bdm_xcvr #(.W(DATA_W)) u_xcvr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .en_n_i(den_n_i),
    .dir_i (dtr_i),
    .cpu_i (mux_ad_i),
    .cpu_o (mux_ad_o),
    .cpu_oe(mux_ad_oe),
    .sys_i (sys_d_i),
    .sys_o (sys_d_o),
    .sys_oe(sys_d_oe)
  );

  assign ctl_d = {mio_i, wr_n_i, rd_n_i};

  bdm_ctrl_buf #(.N(CTRL_N)) u_ctrl (
    .strobe_i(ctl_d),
    .strobe_o(ctl_q)
  );

  assign sys_rd_n_o = ctl_q[0];
  assign sys_wr_n_o = ctl_q[1];
  assign sys_mio_o  = ctl_q[2];

  // R7
  ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $stable(ctl_d) |-> $stable({sys_mio_o, sys_wr_n_o, sys_rd_n_o}));

  // R3
  reset_clear_chk: assert property (@(posedge clk)
    ($rose(rst_n_s) && !ale_i) |-> (lat_addr_o == '0 && !lat_bhe_n_o));
endmodule

// File: tb/bus_demux_if_bench.sv
module bus_demux_if_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] mux_ad_i, mux_ad_o, sys_d_i, sys_d_o;
  logic        mux_ad_oe, sys_d_oe;
  logic [3:0]  mux_hi_i;
  logic        bhe_st_i, ale_i, den_n_i, dtr_i, rd_n_i, wr_n_i, mio_i;
  logic [19:0] lat_addr_o;
  logic        lat_bhe_n_o, sys_rd_n_o, sys_wr_n_o, sys_mio_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_demux_if u_bus_demux_if (
    .clk(clk), .rst_n(rst_n),
    .mux_ad_i(mux_ad_i), .mux_ad_o(mux_ad_o), .mux_ad_oe(mux_ad_oe),
    .mux_hi_i(mux_hi_i), .bhe_st_i(bhe_st_i), .ale_i(ale_i),
    .den_n_i(den_n_i), .dtr_i(dtr_i),
    .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .mio_i(mio_i),
    .lat_addr_o(lat_addr_o), .lat_bhe_n_o(lat_bhe_n_o),
    .sys_d_i(sys_d_i), .sys_d_o(sys_d_o), .sys_d_oe(sys_d_oe),
    .sys_rd_n_o(sys_rd_n_o), .sys_wr_n_o(sys_wr_n_o), .sys_mio_o(sys_mio_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ale_i = 0; den_n_i = 1; dtr_i = 0;
    mux_ad_i = 16'hFFFF; mux_hi_i = 4'hF; bhe_st_i = 1;
    rd_n_i = 1; wr_n_i = 1; mio_i = 0; sys_d_i = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    // R3: held value is cleared by reset
    chk("R3 addr", {12'h0, lat_addr_o}, 32'h0);
    chk("R3 bhe", {31'h0, lat_bhe_n_o}, 32'h0);

    for (int t = 0; t < 256; t++) begin
      logic [15:0] a, d, s;
      logic [3:0]  h;
      logic        b;
      int          m;
      a = 16'(t * 16'h9E37) ^ 16'h5A5A;
      d = ~a ^ 16'(t);
      s = a + 16'h1234;
      h = 4'(t);
      b = t[4];
      m = t % 3;

      @(negedge clk);
      ale_i = 1; den_n_i = 1; mux_ad_i = a; mux_hi_i = h; bhe_st_i = b;
      #1;
      // R1: transparent while strobe high
      chk("R1 addr", {12'h0, lat_addr_o}, {12'h0, h, a});
      chk("R1 bhe", {31'h0, lat_bhe_n_o}, {31'h0, b});

      @(negedge clk);
      ale_i = 0; mux_ad_i = d; mux_hi_i = ~h; bhe_st_i = ~b; sys_d_i = s;
      den_n_i = (m == 0); dtr_i = (m == 1) ? 1'b1 : (m == 0 ? t[3] : 1'b0);
      rd_n_i = t[0]; wr_n_i = t[1]; mio_i = t[2];
      #1;
      // R2: held after strobe falls
      chk("R2 addr", {12'h0, lat_addr_o}, {12'h0, h, a});
      chk("R2 bhe", {31'h0, lat_bhe_n_o}, {31'h0, b});
      if (m == 0) begin
        // R4
        chk("R4 oe", {30'h0, sys_d_oe, mux_ad_oe}, 32'h0);
        chk("R4 data", {sys_d_o, mux_ad_o}, 32'h0);
      end else if (m == 1) begin
        // R5
        chk("R5 oe", {30'h0, sys_d_oe, mux_ad_oe}, 32'h2);
        chk("R5 data", {16'h0, sys_d_o}, {16'h0, d});
      end else begin
        // R6
        chk("R6 oe", {30'h0, sys_d_oe, mux_ad_oe}, 32'h1);
        chk("R6 data", {16'h0, mux_ad_o}, {16'h0, s});
      end
      // R7
      chk("R7 ctrl", {29'h0, sys_mio_o, sys_wr_n_o, sys_rd_n_o}, 32'(t[2:0]));

      @(negedge clk);
      mux_ad_i = d ^ 16'hFFFF; mux_hi_i = h ^ 4'h5;
      #1;
      // R2: still held across a further change of the shared lines
      chk("R2 hold2", {12'h0, lat_addr_o}, {12'h0, h, a});
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule